// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block is a one-stage arithmetic unit for packed sub-word data. It splits a 32-bit operand pair into independent lanes (either two halfword lanes or four byte lanes) and adds or subtracts every lane in the same cycle. No carry or borrow crosses a lane boundary.

Each lane can produce one of three kinds of result. The first is a plain wrapped result. The second is an average-style halving result, in signed or unsigned form. The third is a result clamped to the lane range, again in signed or unsigned form. In halfword mode two crossed operations pair the upper half of `opA` with the lower half of `opB` and the reverse.

The result and a per-lane clamp flag are registered once and presented on the next rising clock edge. A pipeline uses it by holding the inputs in one cycle and taking the outputs in the next.

Top module: `packed_lane_alu`

## Requirements
- R1: While `rstN` is low, `result` and `satFlag` are zero.
- R2: Outputs for a set of inputs appear after exactly one rising clock edge. Before that edge the outputs keep the previous value.
- R3: With `modeSel` = 0 the unit wraps each lane modulo 2^width. `laneSel` = 0 selects halfword lanes and 1 selects byte lanes. `opSel` = 0 adds and 1 subtracts. Lane 0 is the least significant lane, and no carry or borrow passes between lanes.
- R4: `modeSel` = 1 is signed halving. Each lane returns floor((x±y)/2), with x and y read as two's complement and no loss of the carry bit.
- R5: `modeSel` = 2 is unsigned halving. Each lane returns bits [width:1] of the (width+1)-bit two's complement sum or difference of the zero-extended lanes.
- R6: `modeSel` = 3 is signed saturation. A lane result above the signed maximum becomes 0x7F..F, and one below the signed minimum becomes 0x80..0.
- R7: `modeSel` = 4 is unsigned saturation. An add carry clamps the lane to all ones, and a subtract borrow clamps it to zero.
- R8: In halfword mode `opSel` = 2 gives upper lane = A[31:16] + B[15:0] and lower lane = A[15:0] − B[31:16]. It uses the selected mode.
- R9: In halfword mode `opSel` = 3 gives upper lane = A[31:16] − B[15:0] and lower lane = A[15:0] + B[31:16]. It uses the selected mode.
- R10: In byte mode `opSel` = 2 acts as a straight lane add and `opSel` = 3 as a straight lane subtract.
- R11: `satFlag[i]` is 1 only when lane i was clamped in a saturating mode. In halfword mode bits 1:0 flag the lower and upper halves and bits 3:2 are zero.
- R12: `modeSel` values 5, 6 and 7 behave exactly as wrap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| laneSel | input | 1 | 0: two halfword lanes, 1: four byte lanes |
| opSel | input | 2 | 0 add, 1 subtract, 2 crossed add/sub, 3 crossed sub/add |
| modeSel | input | 3 | 0 wrap, 1 signed halving, 2 unsigned halving, 3 signed saturate, 4 unsigned saturate |
| result | output | 32 | Registered packed result |
| satFlag | output | 4 | Registered per-lane clamp flags |

## Verification
Every result and flag is due one rising edge after the inputs are driven, because the only register on the path is the output stage. The bench drives inputs on the falling edge and compares on the following falling edge, half a period after the capturing edge. One dedicated check samples just before that edge to confirm the old value is still present. Reset values are read on a falling edge while reset is held.

// File: rtl/packed_alu_pkg.sv
package packed_alu_pkg;

  localparam int unsigned OP_W   = 2;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned MAX_LANES = 4;

  // operation codes
  localparam logic [OP_W-1:0] OP_ADD = 2'd0;
  localparam logic [OP_W-1:0] OP_SUB = 2'd1;
  localparam logic [OP_W-1:0] OP_XAS = 2'd2;  // upper add, lower sub
  localparam logic [OP_W-1:0] OP_XSA = 2'd3;  // upper sub, lower add

  // mode codes
  localparam logic [MODE_W-1:0] MD_WRAP  = 3'd0;
  localparam logic [MODE_W-1:0] MD_SHALF = 3'd1;
  localparam logic [MODE_W-1:0] MD_UHALF = 3'd2;
  localparam logic [MODE_W-1:0] MD_SSAT  = 3'd3;
  localparam logic [MODE_W-1:0] MD_USAT  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic                 byteMode;
    logic                 swapHalves;
    logic [MAX_LANES-1:0] laneSub;
    logic                 signedOp;
    logic                 halve;
    logic                 saturate;
  } laneCtrl_t;

endpackage

// File: rtl/packed_lane_unit.sv
module packed_lane_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  input  logic         sgn,
  input  logic         halve,
  input  logic         sat,
  output logic [W-1:0] res,
  output logic         clamped
);

  logic [W:0] xExt;
  logic [W:0] yExt;
  logic [W:0] full;

  always_comb begin
    xExt = {sgn & x[W-1], x};
    yExt = {sgn & y[W-1], y};
    full = sub ? (xExt - yExt) : (xExt + yExt);
  end

  always_comb begin
    res     = full[W-1:0];
    clamped = 1'b0;
    if (halve) begin
      // guard bit kept: floor of the exact value divided by two
      res = full[W:1];
    end else if (sat) begin
      if (sgn) begin
        if (full[W] != full[W-1]) begin
          clamped = 1'b1;
          res     = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      end else if (full[W]) begin
        clamped = 1'b1;
        res     = sub ? {W{1'b0}} : {W{1'b1}};
      end
    end
  end

endmodule

// File: rtl/packed_lane_ctrl.sv
module packed_lane_ctrl
  import packed_alu_pkg::*;
(
  input  logic              laneSel,
  input  logic [OP_W-1:0]   opSel,
  input  logic [MODE_W-1:0] modeSel,
  output laneCtrl_t         ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.byteMode   = laneSel;
    ctrl.swapHalves = ~laneSel & opSel[1];
    for (int i = 0; i < int'(MAX_LANES); i++) begin
      ctrl.laneSub[i] = opSel[0];
    end
    if (!laneSel) begin
      // lane 1 (upper half): subtract for SUB and XSA
      ctrl.laneSub[1] = opSel[0];
      // lane 0 (lower half): subtract for SUB and XAS
      ctrl.laneSub[0] = opSel[0] ^ opSel[1];
    end
    ctrl.signedOp = (modeSel == MD_SHALF) || (modeSel == MD_SSAT);
    ctrl.halve    = (modeSel == MD_SHALF) || (modeSel == MD_UHALF);
    ctrl.saturate = (modeSel == MD_SSAT)  || (modeSel == MD_USAT);
  end

endmodule

// File: rtl/packed_lane_datapath.sv
module packed_lane_datapath
  import packed_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [DATA_W-1:0]                     opA,
  input  logic [DATA_W-1:0]                     opB,
  input  laneCtrl_t                             ctrl,
  output logic [DATA_W-1:0]                     result,
  output logic [DATA_W/NARROW_W-1:0]            satFlag
);

  localparam int unsigned WIDE_LANES   = 2;
  localparam int unsigned HALF_W       = DATA_W / WIDE_LANES;
  localparam int unsigned NARROW_LANES = DATA_W / NARROW_W;

  logic [DATA_W-1:0]       halfRes;
  logic [WIDE_LANES-1:0]   halfFlag;
  logic [DATA_W-1:0]       byteRes;
  logic [NARROW_LANES-1:0] byteFlag;

  for (genvar g = 0; g < int'(WIDE_LANES); g++) begin : gHalf
    logic [HALF_W-1:0] ySel;
    assign ySel = ctrl.swapHalves ? opB[(WIDE_LANES-1-g)*HALF_W +: HALF_W]
                                  : opB[g*HALF_W +: HALF_W];
    packed_lane_unit #(.W(HALF_W)) uLane (
      .x      (opA[g*HALF_W +: HALF_W]),
      .y      (ySel),
      .sub    (ctrl.laneSub[g]),
      .sgn    (ctrl.signedOp),
      .halve  (ctrl.halve),
      .sat    (ctrl.saturate),
      .res    (halfRes[g*HALF_W +: HALF_W]),
      .clamped(halfFlag[g])
    );
  end

  for (genvar g = 0; g < int'(NARROW_LANES); g++) begin : gByte
    packed_lane_unit #(.W(NARROW_W)) uLane (
      .x      (opA[g*NARROW_W +: NARROW_W]),
      .y      (opB[g*NARROW_W +: NARROW_W]),
      .sub    (ctrl.laneSub[g]),
      .sgn    (ctrl.signedOp),
      .halve  (ctrl.halve),
      .sat    (ctrl.saturate),
      .res    (byteRes[g*NARROW_W +: NARROW_W]),
      .clamped(byteFlag[g])
    );
  end

  logic [DATA_W-1:0]       resNext;
  logic [NARROW_LANES-1:0] flagNext;

  always_comb begin
    if (ctrl.byteMode) begin
      resNext  = byteRes;
      flagNext = byteFlag;
    end else begin
      resNext  = halfRes;
      flagNext = {{(NARROW_LANES-WIDE_LANES){1'b0}}, halfFlag};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      satFlag <= '0;
    end else begin
      result  <= resNext;
      satFlag <= flagNext;
    end
  end

endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
  import packed_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DATA_W-1:0]          opA,
  input  logic [DATA_W-1:0]          opB,
  input  logic                       laneSel,
  input  logic [1:0]                 opSel,
  input  logic [2:0]                 modeSel,
  output logic [DATA_W-1:0]          result,
  output logic [DATA_W/NARROW_W-1:0] satFlag
);

  laneCtrl_t ctrl;

  packed_lane_ctrl uCtrl (
    .laneSel(laneSel),
    .opSel  (opSel),
    .modeSel(modeSel),
    .ctrl   (ctrl)
  );

  packed_lane_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result),
    .satFlag(satFlag)
  );

endmodule

// File: rtl/packed_lane_alu_chk.sv
module packed_lane_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        laneSel,
  input logic [1:0]  opSel,
  input logic [2:0]  modeSel,
  input logic [31:0] result,
  input logic [3:0]  satFlag
);

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (result == 32'd0 && satFlag == 4'd0));

  // R2: unchanged inputs over two loads give an unchanged output
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && opA == $past(opA) && opB == $past(opB) &&
     laneSel == $past(laneSel) && opSel == $past(opSel) &&
     modeSel == $past(modeSel)) |=> ($stable(result) && $stable(satFlag)));

  // R11: a flag only follows a saturating mode
  assert_flag_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag != 4'd0) |-> ($past(modeSel) == 3'd3 || $past(modeSel) == 3'd4));

  // R11: upper flag bits stay low in halfword mode
  assert_hi_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(laneSel)) |-> (satFlag[3:2] == 2'b00));

  // R6: a clamped signed lower halfword sits on a range limit
  assert_ssat_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 3'd3 && !$past(laneSel) && satFlag[0]) |->
    (result[15:0] == 16'h7FFF || result[15:0] == 16'h8000));

  // R7: an unsigned subtract that clamped gives zero in the lower halfword
  assert_usat_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 3'd4 && !$past(laneSel) && $past(opSel) == 2'd1 &&
     satFlag[0]) |-> (result[15:0] == 16'h0000));

endmodule

bind packed_lane_alu packed_lane_alu_chk u_chk (.*);

// File: tb/packed_lane_alu_tb.sv
module packed_lane_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        laneSel = 1'b0;
  logic [1:0]  opSel = '0;
  logic [2:0]  modeSel = '0;
  logic [31:0] result;
  logic [3:0]  satFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  packed_lane_alu u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .laneSel(laneSel),
    .opSel(opSel), .modeSel(modeSel), .result(result), .satFlag(satFlag)
  );

  // independent integer reference built from the requirements
  function automatic logic [35:0] refModel(logic [31:0] a, logic [31:0] b,
                                           logic ls, logic [1:0] op, logic [2:0] md);
    int w, n, x, y, v, yIdx, mask, hi, lo;
    bit sgn, sub;
    logic [31:0] r;
    logic [3:0]  f;
    r = '0; f = '0;
    w = ls ? 8 : 16;
    n = 32 / w;
    mask = (1 << w) - 1;
    sgn = (md == 3'd1) || (md == 3'd3);
    for (int i = 0; i < n; i++) begin
      yIdx = (!ls && op[1]) ? (1 - i) : i;
      x = int'((a >> (i*w))) & mask;
      y = int'((b >> (yIdx*w))) & mask;
      if (sgn && x >= (1 << (w-1))) x = x - (1 << w);
      if (sgn && y >= (1 << (w-1))) y = y - (1 << w);
      if (ls) sub = op[0];
      else    sub = (op == 2'd1) || (op == 2'd2 && i == 0) || (op == 2'd3 && i == 1);
      v = sub ? x - y : x + y;
      if (md == 3'd1 || md == 3'd2) v = v >>> 1;
      else if (md == 3'd3 || md == 3'd4) begin
        hi = (md == 3'd3) ? (1 << (w-1)) - 1 : mask;
        lo = (md == 3'd3) ? -(1 << (w-1)) : 0;
        if (v > hi) begin v = hi; f[i] = 1'b1; end
        if (v < lo) begin v = lo; f[i] = 1'b1; end
      end
      r = r | (32'(v & mask) << (i*w));
    end
    return {f, r};
  endfunction

  task automatic compare(string tag, logic [31:0] expR, logic [3:0] expF);
    total++;
    if (result !== expR || satFlag !== expF) begin
      bad++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, satFlag, expR, expF);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic ls, logic [1:0] op, logic [2:0] md);
    @(negedge clk);
    opA = a; opB = b; laneSel = ls; opSel = op; modeSel = md;
  endtask

  // drive, then compare one falling edge later (one register on the path)
  task automatic runLit(string tag, logic [31:0] a, logic [31:0] b, logic ls,
                        logic [1:0] op, logic [2:0] md, logic [31:0] expR, logic [3:0] expF);
    logic [35:0] m;
    drive(a, b, ls, op, md);
    @(negedge clk);
    compare(tag, expR, expF);
    m = refModel(a, b, ls, op, md);
    compare({tag, " model"}, m[31:0], m[35:32]);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    drive(32'hFFFF_FFFF, 32'h1234_5678, 1'b1, 2'd0, 3'd4);
    @(negedge clk);
    compare("R1 outputs held at zero in reset", 32'h0, 4'h0);
    rstN = 1'b1;
  endtask

  task automatic testWrap();
    runLit("R3 halfword add no carry", 32'h0001_FFFF, 32'h0001_0001, 1'b0, 2'd0, 3'd0, 32'h0002_0000, 4'h0);
    runLit("R3 byte sub no borrow", 32'h0010_0080, 32'h0101_0001, 1'b1, 2'd1, 3'd0, 32'hFF0F_007F, 4'h0);
  endtask

  task automatic testSignedHalf();
    runLit("R4 halfword signed halving add", 32'h7FFF_FFFF, 32'h7FFF_FFFE, 1'b0, 2'd0, 3'd1, 32'h7FFF_FFFE, 4'h0);
    runLit("R4 byte signed halving sub", 32'h807F_0001, 32'h7F80_0002, 1'b1, 2'd1, 3'd1, 32'h807F_00FF, 4'h0);
  endtask

  task automatic testUnsignedHalf();
    runLit("R5 halfword unsigned halving add", 32'hFFFF_0003, 32'hFFFF_0000, 1'b0, 2'd0, 3'd2, 32'hFFFF_0001, 4'h0);
    runLit("R5 byte unsigned halving sub", 32'h0005_FF00, 32'h0102_00FF, 1'b1, 2'd1, 3'd2, 32'hFF01_7F80, 4'h0);
  endtask

  task automatic testSignedSat();
    runLit("R6 halfword signed sat add", 32'h7000_9000, 32'h2000_9000, 1'b0, 2'd0, 3'd3, 32'h7FFF_8000, 4'b0011);
    runLit("R6 byte signed sat sub", 32'h807F_1005, 32'h01FF_2003, 1'b1, 2'd1, 3'd3, 32'h807F_F002, 4'b1100);
  endtask

  task automatic testUnsignedSat();
    runLit("R7 halfword unsigned sat add", 32'hFFF0_0001, 32'h0020_0002, 1'b0, 2'd0, 3'd4, 32'hFFFF_0003, 4'b0010);
    runLit("R7 byte unsigned sat sub", 32'h1000_0580, 32'h2001_057F, 1'b1, 2'd1, 3'd4, 32'h0000_0001, 4'b1100);
  endtask

  task automatic testCross();
    runLit("R8 crossed add/sub wrap", 32'h0010_0020, 32'h0003_0005, 1'b0, 2'd2, 3'd0, 32'h0015_001D, 4'h0);
    runLit("R8 crossed add/sub signed sat", 32'h7FFF_8000, 32'h0001_0001, 1'b0, 2'd2, 3'd3, 32'h7FFF_8000, 4'b0011);
    runLit("R9 crossed sub/add wrap", 32'h0010_0020, 32'h0003_0005, 1'b0, 2'd3, 3'd0, 32'h000B_0023, 4'h0);
    runLit("R9 crossed sub/add unsigned halving", 32'h0000_FFFF, 32'h0001_0001, 1'b0, 2'd3, 3'd2, 32'hFFFF_8000, 4'h0);
  endtask

  task automatic testCrossByte();
    runLit("R10 byte mode op2 adds", 32'h0102_0304, 32'h1010_1010, 1'b1, 2'd2, 3'd0, 32'h1112_1314, 4'h0);
    runLit("R10 byte mode op3 subtracts", 32'h0102_0304, 32'h1010_1010, 1'b1, 2'd3, 3'd0, 32'hF1F2_F3F4, 4'h0);
  endtask

  task automatic testReservedAndFlags();
    runLit("R12 mode 5 wraps", 32'h7000_9000, 32'h2000_9000, 1'b0, 2'd0, 3'd5, 32'h9000_2000, 4'h0);
    runLit("R12 mode 7 wraps bytes", 32'hFF80_7F01, 32'h0180_01FF, 1'b1, 2'd0, 3'd7, 32'h0000_8000, 4'h0);
    runLit("R11 no flag on wrap overflow", 32'hFFFF_FFFF, 32'h0001_0001, 1'b0, 2'd0, 3'd0, 32'h0000_0000, 4'h0);
  endtask

  task automatic testLatency();
    drive(32'h0000_0001, 32'h0000_0001, 1'b0, 2'd0, 3'd0);
    @(negedge clk);
    compare("R2 first value", 32'h0000_0002, 4'h0);
    opA = 32'h0000_0010;
    #5;
    compare("R2 old value before edge", 32'h0000_0002, 4'h0);
    @(negedge clk);
    compare("R2 new value after one edge", 32'h0000_0011, 4'h0);
  endtask

  task automatic testSweep();
    logic [31:0] lfsr;
    logic [35:0] m;
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr, {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_A5A5, k[0], k[2:1], 3'(k[5:3] % 6));
      @(negedge clk);
      m = refModel(opA, opB, laneSel, opSel, modeSel);
      compare("R3 R4 R5 R6 R7 R8 R9 R10 sweep", m[31:0], m[35:32]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testLatency();
    testWrap();
    testSignedHalf();
    testUnsignedHalf();
    testSignedSat();
    testUnsignedSat();
    testCross();
    testCrossByte();
    testReservedAndFlags();
    testSweep();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule